// File: doc/BRIEF.md
# Vector Rest Load Unit

This unit carries out the "rest" half of an unaligned 128-bit vector load. From a 4 KB data memory it fetches the bytes that lie between the enclosing 16-byte aligned line start and the byte just below the effective address. It places them at the high-numbered end of a vector register. Byte lanes outside that range are left alone through per-byte write enables. A load whose address is already 16-byte aligned moves no data at all.

The effective address is the scalar base value plus the sign-extended 7-bit offset field. The memory is a synchronous read port addressed by 16-byte line, and its data returns one cycle after the request. The register file write happens three cycles after the load is accepted, so the fourth instruction after the load can use the result. Any instruction that names the pending target in one of its register fields while the write is outstanding is held by `stall`.

Top module: `vrest_load_unit`

## Requirements
- R1: A rest load is an instruction with bits 31:26 equal to 110010 and bits 15:11 equal to 00101; no other instruction word raises `mem_rd` or causes a register write.
- R2: The effective address is `base_val` plus bits 6:0 sign-extended to 32 bits. `mem_line` carries bits 11:4 of that address in the cycle the load is accepted.
- R3: With n = address bits 3:0, vector element e (bits 127-8e down to 120-8e, element 0 most significant) receives memory line byte e-(16-n) for every e from 16-n to 15. The line bytes are numbered the same way.
- R4: `vrf_be` bit e enables element e, and exactly bits 16-n through 15 are set during the write, so all lower elements keep their contents.
- R5: A rest load with address bits 3:0 equal to zero raises neither `mem_rd` nor `vrf_we`, and it causes no later stall.
- R6: A rest load accepted in cycle t reads `mem_rdata` in cycle t+1 and asserts `vrf_we` in cycle t+3 with `vrf_addr` equal to bits 20:16 of its word.
- R7: During cycles t+1 to t+3, `stall` is high exactly for valid instructions whose bits 20:16 or 15:11 equal the pending target.
- R8: A valid rest load that arrives while a write is pending is stalled.
- R9: Reset clears any pending load. While in reset and afterwards, `stall`, `mem_rd` and `vrf_we` stay low until a new load is accepted.
- R10: A stalled instruction is not accepted: a stalled rest load raises no `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word being issued |
| base_val | input | 32 | Value of the scalar base register |
| stall | output | 1 | Hold the presented instruction this cycle |
| mem_rd | output | 1 | Read strobe to data memory |
| mem_line | output | 8 | 16-byte line index into data memory |
| mem_rdata | input | 128 | Line returned one cycle after `mem_rd` |
| vrf_we | output | 1 | Vector register write strobe |
| vrf_addr | output | 5 | Vector register being written |
| vrf_be | output | 16 | Per-element write enables (bit e = element e) |
| vrf_wdata | output | 128 | Write data, element 0 in bits 127:120 |

## Verification
The completing register write and the interlock stall fall in the same cycle whenever a dependent instruction reaches the third delay slot. A queued rest load also meets the write in that cycle, and it is held there and then accepted one cycle later. Directed sequences place dependent and independent instructions in each of the three delay slots and in the slot after them. Seeded random traffic over a small set of register numbers makes these collisions frequent. In every cycle the bench recomputes the stall, the memory request and the write lanes and data from its own model of the countdown, and compares them to the ports.

// File: rtl/vrl_pkg.sv
package vrl_pkg;
  localparam int LANES  = 16;
  localparam int LANE_W = 8;
  localparam int VREG_W = LANES * LANE_W;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 7;
  localparam int RIDX_W = 5;
  localparam int IDX_W  = $clog2(LANES);
  localparam int LINE_W = ADDR_W - IDX_W;

  typedef logic [IDX_W-1:0]  rest_cnt_t;
  typedef logic [RIDX_W-1:0] reg_idx_t;

  // Scalar base plus sign-extended offset field.
  function automatic logic [31:0] eff_addr(input logic [31:0] base,
                                           input logic [OFS_W-1:0] ofs);
    return base + {{(32-OFS_W){ofs[OFS_W-1]}}, ofs};
  endfunction

  // Element e enabled when e >= LANES - n (none when n == 0).
  function automatic logic [LANES-1:0] lane_enable(input rest_cnt_t n);
    logic [LANES-1:0] en;
    en = '0;
    for (int i = 0; i < LANES; i++)
      en[i] = (n != '0) && (i >= LANES - int'(n));
    return en;
  endfunction

  // Move the low-addressed n bytes of the line to the top-numbered elements.
  function automatic logic [VREG_W-1:0] place_rest(input logic [VREG_W-1:0] line,
                                                   input rest_cnt_t n);
    if (n == '0) return '0;
    return line >> (LANE_W * (LANES - int'(n)));
  endfunction
endpackage

// File: rtl/vrl_decode.sv
module vrl_decode
  import vrl_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'b110010,
  parameter logic [4:0] SUB_OP   = 5'b00101
) (
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [31:0]       base_val,
  output logic              is_rest,
  output reg_idx_t          src_a,
  output reg_idx_t          src_b,
  output logic [LINE_W-1:0] line_idx,
  output rest_cnt_t         rest_n
);
  logic [31:0] ea;
  logic        unused_bits;

  assign ea       = eff_addr(base_val, instr[OFS_W-1:0]);
  assign is_rest  = issue_valid && (instr[31:26] == MAJOR_OP) && (instr[15:11] == SUB_OP);
  assign src_a    = instr[20:16];
  assign src_b    = instr[15:11];
  assign line_idx = ea[ADDR_W-1:IDX_W];
  assign rest_n   = ea[IDX_W-1:0];
  assign unused_bits = ^{instr[25:21], instr[10:OFS_W], ea[31:ADDR_W]};
endmodule

// File: rtl/vrl_interlock.sv
module vrl_interlock
  import vrl_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue_valid,
  input  logic      is_rest,
  input  reg_idx_t  src_a,
  input  reg_idx_t  src_b,
  input  rest_cnt_t rest_n,
  output logic      stall,
  output logic      start,
  output logic      write_now,
  output reg_idx_t  pend_vt,
  output rest_cnt_t pend_n
);
  localparam int CW = $clog2(SLOTS + 1);

  logic [CW-1:0] count;
  logic          busy;
  logic          accept;

  assign busy      = count != '0;
  assign stall     = issue_valid && busy &&
                     (is_rest || src_a == pend_vt || src_b == pend_vt);
  assign accept    = is_rest && !stall;
  assign start     = accept && (rest_n != '0);
  assign write_now = count == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      pend_vt <= '0;
      pend_n  <= '0;
    end else if (start) begin
      count   <= CW'(SLOTS);
      pend_vt <= src_a;
      pend_n  <= rest_n;
    end else if (busy) begin
      count   <= count - CW'(1);
    end
  end

  assert_aligned_no_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rest_n == '0 && !busy) |=> !busy);
  assert_no_start_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));
  assert_start_loads_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pend_vt == $past(src_a)));
endmodule

// File: rtl/vrl_datapath.sv
module vrl_datapath
  import vrl_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              write_now,
  input  reg_idx_t          pend_vt,
  input  rest_cnt_t         pend_n,
  input  logic [VREG_W-1:0] mem_rdata,
  output logic              vrf_we,
  output reg_idx_t          vrf_addr,
  output logic [LANES-1:0]  vrf_be,
  output logic [VREG_W-1:0] vrf_wdata
);
  logic              cap_q;
  logic [VREG_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      data_q <= '0;
    end else begin
      cap_q <= start;
      if (cap_q) data_q <= place_rest(mem_rdata, pend_n);
    end
  end

  assign vrf_we    = write_now;
  assign vrf_addr  = pend_vt;
  assign vrf_be    = write_now ? lane_enable(pend_n) : '0;
  assign vrf_wdata = data_q;

  // Checker counter: cycles since the last accepted load.
  logic [7:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)               age <= '0;
    else if (start)           age <= 8'd1;
    else if (age != '0 && age != 8'hFF) age <= age + 8'd1;
  end

  assert_write_after_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> (age == 8'(SLOTS)));
  assert_top_lane_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> vrf_be[LANES-1]);
  assert_no_lanes_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vrf_we |-> (vrf_be == '0));
endmodule

// File: rtl/vrest_load_unit.sv
module vrest_load_unit
  import vrl_pkg::*;
#(
  parameter int         SLOTS    = 3,
  parameter logic [5:0] MAJOR_OP = 6'b110010,
  parameter logic [4:0] SUB_OP   = 5'b00101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [31:0]       base_val,
  output logic              stall,
  output logic              mem_rd,
  output logic [LINE_W-1:0] mem_line,
  input  logic [VREG_W-1:0] mem_rdata,
  output logic              vrf_we,
  output logic [RIDX_W-1:0] vrf_addr,
  output logic [LANES-1:0]  vrf_be,
  output logic [VREG_W-1:0] vrf_wdata
);
  logic      is_rest, start, write_now;
  reg_idx_t  src_a, src_b, pend_vt;
  rest_cnt_t rest_n, pend_n;

  vrl_decode #(.MAJOR_OP(MAJOR_OP), .SUB_OP(SUB_OP)) u_dec (
    .issue_valid(issue_valid), .instr(instr), .base_val(base_val),
    .is_rest(is_rest), .src_a(src_a), .src_b(src_b),
    .line_idx(mem_line), .rest_n(rest_n));

  vrl_interlock #(.SLOTS(SLOTS)) u_ilk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .is_rest(is_rest),
    .src_a(src_a), .src_b(src_b), .rest_n(rest_n), .stall(stall),
    .start(start), .write_now(write_now), .pend_vt(pend_vt), .pend_n(pend_n));

  vrl_datapath #(.SLOTS(SLOTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .write_now(write_now),
    .pend_vt(pend_vt), .pend_n(pend_n), .mem_rdata(mem_rdata),
    .vrf_we(vrf_we), .vrf_addr(vrf_addr), .vrf_be(vrf_be), .vrf_wdata(vrf_wdata));

  assign mem_rd = start;

  assert_stall_blocks_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mem_rd);
  assert_read_only_when_decoded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (issue_valid && instr[31:26] == MAJOR_OP && instr[15:11] == SUB_OP));
endmodule

// File: tb/vrest_load_unit_test.sv
module vrest_load_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  instr, base_val;
  logic         stall, mem_rd, vrf_we;
  logic [7:0]   mem_line;
  logic [127:0] mem_rdata;
  logic [4:0]   vrf_addr;
  logic [15:0]  vrf_be;
  logic [127:0] vrf_wdata;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model of the interlock
  int         m_cnt = 0;
  logic [4:0] m_vt = '0;
  logic [3:0] m_n = '0;
  logic [7:0] m_line = '0;

  always #5 clk = ~clk;

  vrest_load_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .base_val(base_val), .stall(stall), .mem_rd(mem_rd), .mem_line(mem_line),
    .mem_rdata(mem_rdata), .vrf_we(vrf_we), .vrf_addr(vrf_addr),
    .vrf_be(vrf_be), .vrf_wdata(vrf_wdata));

  function automatic logic [127:0] memf(input logic [7:0] line);
    logic [127:0] d;
    for (int k = 0; k < 16; k++)
      d[127-8*k -: 8] = 8'(int'(line) * 13 + k * 29 + 1);
    return d;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_line);

  function automatic logic [31:0] mk_rest(input logic [4:0] vt, input logic [6:0] ofs);
    return {6'b110010, 5'd2, vt, 5'b00101, 4'd0, ofs};
  endfunction
  function automatic logic [31:0] mk_other(input logic [5:0] op, input logic [4:0] a,
                                           input logic [4:0] b);
    return {op, 5'd1, a, b, 11'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [31:0] i, input logic [31:0] b,
                       output logic st);
    logic        is_ld, acc;
    logic [31:0] ea;
    logic [15:0] be;
    logic [127:0] line, exp_d, msk;
    @(negedge clk);
    issue_valid = v; instr = i; base_val = b;
    #1;
    is_ld = v && i[31:26] == 6'b110010 && i[15:11] == 5'b00101;
    st = v && m_cnt != 0 && (is_ld || i[20:16] == m_vt || i[15:11] == m_vt);
    chk(stall == st, is_ld ? "R8 stall" : "R7 stall", 128'(stall), 128'(st));
    acc = is_ld && !st;
    ea = b + {{25{i[6]}}, i[6:0]};
    if (is_ld && st)           chk(mem_rd == 1'b0, "R10 mem_rd", 128'(mem_rd), 128'(0));
    else if (!is_ld)           chk(mem_rd == 1'b0, "R1 mem_rd", 128'(mem_rd), 128'(0));
    else if (ea[3:0] == 4'd0)  chk(mem_rd == 1'b0, "R5 mem_rd", 128'(mem_rd), 128'(0));
    else begin
      chk(mem_rd == 1'b1, "R2 mem_rd", 128'(mem_rd), 128'(1));
      chk(mem_line == ea[11:4], "R2 mem_line", 128'(mem_line), 128'(ea[11:4]));
    end
    if (m_cnt == 1) begin
      line = memf(m_line);
      be = '0; exp_d = '0; msk = '0;
      for (int e = 0; e < 16; e++)
        if (e >= 16 - int'(m_n)) begin
          be[e] = 1'b1;
          msk[127-8*e -: 8] = 8'hFF;
          exp_d[127-8*e -: 8] = line[127-8*(e-(16-int'(m_n))) -: 8];
        end
      chk(vrf_we == 1'b1, "R6 vrf_we", 128'(vrf_we), 128'(1));
      chk(vrf_addr == m_vt, "R6 vrf_addr", 128'(vrf_addr), 128'(m_vt));
      chk(vrf_be == be, "R4 vrf_be", 128'(vrf_be), 128'(be));
      chk((vrf_wdata & msk) == exp_d, "R3 vrf_wdata", vrf_wdata & msk, exp_d);
    end else begin
      chk(vrf_we == 1'b0, "R6 idle vrf_we", 128'(vrf_we), 128'(0));
      chk(vrf_be == 16'd0, "R4 idle vrf_be", 128'(vrf_be), 128'(0));
    end
    if (acc && ea[3:0] != 4'd0) begin
      m_cnt = 3; m_vt = i[20:16]; m_n = ea[3:0]; m_line = ea[11:4];
    end else if (m_cnt > 0) m_cnt--;
  endtask

  task automatic issue(input logic [31:0] i, input logic [31:0] b);
    logic st;
    do cycle(1'b1, i, b, st); while (st);
  endtask

  task automatic idle(input int k);
    logic st;
    for (int j = 0; j < k; j++) cycle(1'b0, 32'd0, 32'd0, st);
  endtask

  task automatic do_reset(input int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      rst_n = 1'b0; issue_valid = 1'b0;
      #1;
      chk(stall == 1'b0 && mem_rd == 1'b0 && vrf_we == 1'b0, "R9 in reset",
          128'({stall, mem_rd, vrf_we}), 128'(0));
    end
    m_cnt = 0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    issue_valid = 0; instr = 0; base_val = 0; mem_rdata = '0; rst_n = 0;
    do_reset(3);
    idle(2);                                         // R9 quiet after reset
    issue(mk_rest(5'd3, 7'd0), 32'h100);             // R5 aligned, no write
    issue(mk_other(6'h12, 5'd3, 5'd3), 0);           // R5 no stall
    idle(3);
    issue(mk_rest(5'd4, 7'd0), 32'h105);             // n=5
    issue(mk_other(6'h12, 5'd4, 5'd9), 0);           // R7 stalls through slots
    idle(2);
    issue(mk_rest(5'd7, 7'd0), 32'h20F);             // n=15
    issue(mk_other(6'h12, 5'd1, 5'd2), 0);           // R7 independent
    issue(mk_rest(5'd8, 7'd0), 32'h231);             // R8 busy stall
    idle(4);
    issue({6'b110010, 5'd0, 5'd6, 5'b00100, 4'd0, 7'd3}, 32'h44); // R1 other variant
    issue(mk_rest(5'd9, 7'h7F), 32'h300);            // R2 negative offset
    idle(1);
    issue(mk_other(6'h12, 5'd0, 5'd9), 0);           // R7 third slot meets write
    issue(mk_rest(5'd10, 7'd0), 32'hFFFF_F001);      // R2 n=1, high bits dropped
    issue(mk_rest(5'd11, 7'd5), 32'hA);              // R8 held then taken
    idle(4);
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4)      issue(mk_rest(5'($urandom % 8), 7'($urandom)), $urandom);
      else if (r < 8) issue(mk_other(6'($urandom % 32), 5'($urandom % 8), 5'($urandom % 8)), 0);
      else            idle(1);
    end
    idle(4);
    issue(mk_rest(5'd12, 7'd0), 32'h53);             // R9 reset mid-flight
    idle(1);
    do_reset(2);
    m_cnt = 0;
    issue(mk_other(6'h12, 5'd12, 5'd12), 0);         // R9 no stall, no write
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule